// File: doc/BRIEF.md
# Link Fast-Command Decoder with Test-Frame Source

This block sits on the receive side of a serial link, just after the 8b/10b character decoder, and runs in the 50 MHz link clock domain. It scans the decoded character stream for two-character fast commands. A command is the control character K28.3 followed by one data character that selects the action. Characters presented while the valid strobe is low are skipped, so they do not break up a command.

The commands act on a 16-bit spill identifier and on a test-frame source. The spill identifier can be cleared or advanced by one. The frame source can send one frame, a burst of frames, or frames without a stop until it is told to halt. Each frame carries the current spill identifier, so the data concentrator can test its receive path without any front-end data.

Top module: `link_fastcmd_top`

## Requirements
- R1: A command is the byte 0x7C with the control flag set (K28.3), followed by the next character presented with the valid strobe high. Cycles with the strobe low between the two characters are skipped.
- R2: Data byte 0x05 after the prefix sets the spill identifier to zero.
- R3: Data byte 0x25 after the prefix adds one to the spill identifier, wrapping modulo 2^16.
- R4: Data byte 0x65 after the prefix sends exactly one test frame.
- R5: Data byte 0x85 after the prefix sends BURST_LEN test frames (8 by default).
- R6: Data byte 0xA5 after the prefix toggles continuous mode. While continuous mode is on, frames follow each other with one idle cycle between them. When it is turned off, the frame in progress finishes and no new frame starts.
- R7: A prefix followed by any other data byte, or by a control character other than K28.3, has no effect. A repeated K28.3 restarts recognition. A command data byte that arrives without a prefix has no effect.
- R8: A frame is 3 + PAYLOAD_LEN + 1 bytes long: header 0x5C, the spill identifier taken at frame start (high byte first), payload bytes 0, 1, 2, ..., then trailer 0xC5. pkt_valid is high on every byte, pkt_sop only on the first byte and pkt_eop only on the last.
- R9: A send request (one frame or a burst) is held and served after the current frame if no frames are still owed. If frames are still owed from an earlier request, the new request is dropped.
- R10: busy is high while a frame is being sent, while frames are owed, or while continuous mode is on. It is low otherwise.
- R11: Reset sets the spill identifier to zero, turns continuous mode off, returns the decoder to idle and drives pkt_valid and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock (50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_data | input | 8 | Decoded character |
| rx_is_k | input | 1 | Character is a control character |
| rx_valid | input | 1 | Character strobe |
| pkt_data | output | 8 | Test-frame byte |
| pkt_valid | output | 1 | Frame byte valid |
| pkt_sop | output | 1 | First byte of a frame |
| pkt_eop | output | 1 | Last byte of a frame |
| busy | output | 1 | Frame in progress, frames owed, or continuous mode on |

## Verification
The hardest situation to reach is a send request that arrives while a frame is already on the wire, with or without frames still owed. Timing alone decides whether the request is held or dropped. The stimulus waits for pkt_valid to rise before it sends further single-frame or burst requests, so each request lands inside a frame. The bench then counts the whole frames that follow. Aborted prefixes, gaps in the valid strobe and random noise bytes are mixed with directed spill commands, and every frame's identifier is compared against a value the bench tracks.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned SPILL_W = 16;

  localparam logic [7:0] K_PREFIX = 8'h7C;
  localparam logic [7:0] D_CLR    = 8'h05;
  localparam logic [7:0] D_INC    = 8'h25;
  localparam logic [7:0] D_ONE    = 8'h65;
  localparam logic [7:0] D_BURST  = 8'h85;
  localparam logic [7:0] D_CONT   = 8'hA5;
  localparam logic [7:0] FRM_HDR  = 8'h5C;
  localparam logic [7:0] FRM_TRL  = 8'hC5;

  typedef struct packed {
    logic clr;
    logic inc;
    logic one;
    logic burst;
    logic cont;
  } cmd_t;
endpackage

// File: rtl/lfc_cmd_decode.sv
module lfc_cmd_decode
  import lfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_is_k,
  input  logic       rx_valid,
  output cmd_t       cmd
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    cmd     = '0;
    if (rx_valid) begin
      if (rx_is_k) begin
        armed_d = (rx_data == K_PREFIX);
      end else begin
        armed_d = 1'b0;
        if (armed_q) begin
          case (rx_data)
            D_CLR:   cmd.clr   = 1'b1;
            D_INC:   cmd.inc   = 1'b1;
            D_ONE:   cmd.one   = 1'b1;
            D_BURST: cmd.burst = 1'b1;
            D_CONT:  cmd.cont  = 1'b1;
            default: cmd       = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R7: a control character never produces an action
  a_r7_k_no_action: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_is_k) |-> (cmd == '0));
  // R1: a command needs a strobed character
  a_r1_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (cmd == '0));
endmodule

// File: rtl/lfc_pkt_ctrl.sv
module lfc_pkt_ctrl #(
  parameter int unsigned BURST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_one,
  input  logic req_burst,
  input  logic cont_toggle,
  input  logic gen_busy,
  output logic start,
  output logic busy
);
  localparam int unsigned RW = $clog2(BURST_LEN + 1);

  logic [RW-1:0] rem_q, rem_d;
  logic          cont_q, cont_d;

  assign start = !gen_busy && ((rem_q != '0) || cont_q);
  assign busy  = gen_busy || (rem_q != '0) || cont_q;

  always_comb begin
    rem_d  = rem_q;
    cont_d = cont_q ^ cont_toggle;
    if (start && (rem_q != '0)) rem_d = rem_q - RW'(1);
    if (rem_q == '0) begin
      if (req_one)        rem_d = RW'(1);
      else if (req_burst) rem_d = RW'(BURST_LEN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cont_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      cont_q <= cont_d;
    end
  end

  // R9: owed count never exceeds a burst
  a_r9_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= RW'(BURST_LEN));
  // R9: a request with nothing owed is held
  a_r9_one_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_one && rem_q == '0) |=> (rem_q == RW'(1)));
  // R5: a burst request with nothing owed loads the full count
  a_r5_burst_load: assert property (@(posedge clk) disable iff (!rst_n)
    (req_burst && rem_q == '0) |=> (rem_q == RW'(BURST_LEN)));
endmodule

// File: rtl/lfc_pkt_gen.sv
module lfc_pkt_gen
  import lfc_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [SPILL_W-1:0] spill,
  output logic [7:0]         pkt_data,
  output logic               pkt_valid,
  output logic               pkt_sop,
  output logic               pkt_eop,
  output logic               busy
);
  localparam int unsigned FRAME_LEN = PAYLOAD_LEN + 4;
  localparam int unsigned IW        = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] LAST    = IW'(FRAME_LEN - 1);

  logic               busy_q, busy_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [SPILL_W-1:0] sp_q, sp_d;
  logic [IW-1:0]      pay_idx;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sp_d   = sp_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sp_d   = spill;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sp_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sp_q   <= sp_d;
    end
  end

  assign pay_idx = idx_q - IW'(3);

  always_comb begin
    if (idx_q == '0)          pkt_data = FRM_HDR;
    else if (idx_q == IW'(1)) pkt_data = sp_q[15:8];
    else if (idx_q == IW'(2)) pkt_data = sp_q[7:0];
    else if (idx_q == LAST)   pkt_data = FRM_TRL;
    else                      pkt_data = 8'(pay_idx);
  end

  assign pkt_valid = busy_q;
  assign pkt_sop   = busy_q && (idx_q == '0);
  assign pkt_eop   = busy_q && (idx_q == LAST);
  assign busy      = busy_q;

  // R8: a new frame is never started over a running one
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R8: a frame end is followed by an idle cycle
  a_r8_gap_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_eop |=> !pkt_valid);
  // R8: first byte follows a start request
  a_r8_sop_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pkt_sop && pkt_data == FRM_HDR));
endmodule

// File: rtl/link_fastcmd_top.sv
module link_fastcmd_top
  import lfc_pkg::*;
#(
  parameter int unsigned BURST_LEN   = 8,
  parameter int unsigned PAYLOAD_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_data,
  input  logic       rx_is_k,
  input  logic       rx_valid,
  output logic [7:0] pkt_data,
  output logic       pkt_valid,
  output logic       pkt_sop,
  output logic       pkt_eop,
  output logic       busy
);
  cmd_t               cmd;
  logic               gen_start, gen_busy;
  logic [SPILL_W-1:0] spill_q, spill_d;

  lfc_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_is_k(rx_is_k),
    .rx_valid(rx_valid), .cmd(cmd)
  );

  always_comb begin
    spill_d = spill_q;
    if (cmd.clr)      spill_d = '0;
    else if (cmd.inc) spill_d = spill_q + SPILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spill_q <= '0;
    else        spill_q <= spill_d;
  end

  lfc_pkt_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_one(cmd.one), .req_burst(cmd.burst),
    .cont_toggle(cmd.cont), .gen_busy(gen_busy), .start(gen_start), .busy(busy)
  );

  lfc_pkt_gen #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .spill(spill_q),
    .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .busy(gen_busy)
  );

  // R2: clear command zeroes the identifier
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> (spill_q == '0));
  // R3: increment command adds one
  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.inc |=> (spill_q == $past(spill_q) + SPILL_W'(1)));
  // R7: identifier holds without a spill command
  a_r7_spill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.clr && !cmd.inc) |=> $stable(spill_q));
  // R10: busy covers any frame on the wire
  a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> busy);
endmodule

// File: tb/sim_link_fastcmd_top.sv
module sim_link_fastcmd_top;
  localparam int PAY = 4;
  localparam int BL  = 8;
  localparam int FL  = PAY + 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_is_k = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] pkt_data;
  logic       pkt_valid, pkt_sop, pkt_eop, busy;

  int n_chk = 0;
  int n_bad = 0;
  int frames = 0;
  int fidx = 0;
  bit f_ok = 1'b1;
  logic [15:0] exp_spill = 16'h0;

  always #4 clk = ~clk;

  link_fastcmd_top #(.BURST_LEN(BL), .PAYLOAD_LEN(PAY)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_is_k(rx_is_k),
    .rx_valid(rx_valid), .pkt_data(pkt_data), .pkt_valid(pkt_valid),
    .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .busy(busy)
  );

  function automatic logic [7:0] exp_byte(int i, logic [15:0] s);
    if (i == 0)      return 8'h5C;
    if (i == 1)      return s[15:8];
    if (i == 2)      return s[7:0];
    if (i == FL - 1) return 8'hC5;
    return 8'(i - 3);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // frame monitor, R8 checked for each completed frame
  always @(negedge clk) begin
    if (rst_n && pkt_valid) begin
      if (pkt_sop) begin
        fidx = 0;
        f_ok = 1'b1;
      end
      if (pkt_data !== exp_byte(fidx, exp_spill)) begin
        f_ok = 1'b0;
        $display("FAIL R8 byte %0d actual=%0h expected=%0h", fidx, pkt_data,
                 exp_byte(fidx, exp_spill));
      end
      if (pkt_eop) begin
        check(f_ok && fidx == FL - 1, "R8 frame", fidx, FL - 1);
        frames++;
      end
      fidx++;
    end
  end

  task automatic put(logic [7:0] d, logic k);
    @(negedge clk);
    rx_data = d; rx_is_k = k; rx_valid = 1'b1;
  endtask

  task automatic gap();
    @(negedge clk);
    rx_valid = 1'b0; rx_is_k = 1'b0; rx_data = 8'($urandom);
  endtask

  task automatic fcmd(logic [7:0] d);
    put(8'h7C, 1'b1);
    put(d, 1'b0);
    gap();
  endtask

  task automatic wait_quiet();
    int t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 3000) check(1'b0, "R10 busy stuck", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_frame_on();
    int t = 0;
    while (!pkt_valid && t < 100) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    check(pkt_valid == 1'b0, "R11 valid", pkt_valid, 0);
    check(busy == 1'b0, "R11 busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R11 busy after release", busy, 0);

    // R4, R11: one frame, identifier zero after reset
    f0 = frames;
    fcmd(8'h65);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R10 busy during frame", busy, 1);
    wait_quiet();
    check(frames - f0 == 1, "R4 single frame", frames - f0, 1);

    // R3: three increments
    repeat (3) begin fcmd(8'h25); exp_spill++; end
    f0 = frames;
    fcmd(8'h65); wait_quiet();
    check(frames - f0 == 1, "R3 frame after inc", frames - f0, 1);

    // R2: clear
    fcmd(8'h05); exp_spill = 16'h0;
    f0 = frames;
    fcmd(8'h65); wait_quiet();
    check(frames - f0 == 1, "R2 frame after clear", frames - f0, 1);

    // R5: burst
    fcmd(8'h25); exp_spill++;
    f0 = frames;
    fcmd(8'h85); wait_quiet();
    check(frames - f0 == BL, "R5 burst count", frames - f0, BL);
    check(busy == 1'b0, "R10 idle after burst", busy, 0);

    // R6: continuous on then off
    f0 = frames;
    fcmd(8'hA5);
    repeat (60) @(negedge clk);
    check(busy == 1'b1, "R6 busy in continuous", busy, 1);
    check(frames - f0 >= 5, "R6 continuous frames", frames - f0, 5);
    fcmd(8'hA5);
    wait_quiet();
    f0 = frames;
    repeat (40) @(negedge clk);
    check(frames == f0, "R6 stopped", frames - f0, 0);
    check(busy == 1'b0, "R10 idle after stop", busy, 0);

    // R7: bad data after prefix, foreign K, bare data byte
    fcmd(8'h06);
    put(8'h7C, 1'b1); put(8'hBC, 1'b1); put(8'h25, 1'b0); gap();
    put(8'h25, 1'b0); gap();
    put(8'h7C, 1'b1); put(8'h65, 1'b1); gap();
    check(busy == 1'b0, "R7 no send from K data", busy, 0);
    f0 = frames;
    fcmd(8'h65); wait_quiet();
    check(frames - f0 == 1, "R7 aborted commands ignored", frames - f0, 1);

    // R7: repeated prefix restarts; R1: strobe gaps are skipped
    put(8'h7C, 1'b1); put(8'h7C, 1'b1); put(8'h25, 1'b0); gap(); exp_spill++;
    put(8'h7C, 1'b1); gap(); gap(); gap(); put(8'h25, 1'b0); gap(); exp_spill++;
    f0 = frames;
    fcmd(8'h65); wait_quiet();
    check(frames - f0 == 1, "R1 gapped command", frames - f0, 1);

    // R9: two requests during a single frame -> one held, one dropped
    f0 = frames;
    fcmd(8'h65);
    wait_frame_on();
    fcmd(8'h65);
    fcmd(8'h65);
    wait_quiet();
    check(frames - f0 == 2, "R9 held one request", frames - f0, 2);

    // R9: request during a burst is dropped
    f0 = frames;
    fcmd(8'h85);
    wait_frame_on();
    fcmd(8'h65);
    wait_quiet();
    check(frames - f0 == BL, "R9 dropped during burst", frames - f0, BL);

    // random mix of spill commands and noise, R2 R3 R7
    for (int it = 0; it < 60; it++) begin
      int sel = int'($urandom_range(0, 4));
      case (sel)
        0: begin fcmd(8'h05); exp_spill = 16'h0; end
        1, 2: begin fcmd(8'h25); exp_spill++; end
        3: begin
          logic [7:0] b = 8'($urandom);
          if (b == 8'h05 || b == 8'h25 || b == 8'h65 || b == 8'h85 || b == 8'hA5)
            b = 8'h00;
          fcmd(b);
        end
        default: begin put(8'($urandom), 1'b0); gap(); end
      endcase
      if (it % 6 == 5) begin
        f0 = frames;
        fcmd(8'h65); wait_quiet();
        check(frames - f0 == 1, "R3 random frame", frames - f0, 1);
      end
    end

    finish_run();
  end
endmodule